// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Hazard Interlock

This block guards the issue stage of a multiply-accumulate unit that owns four accumulators. Decoded instructions arrive one per cycle on a valid/ready handshake. Each carries a 2-bit kind code and a 2-bit accumulator index. The block remembers the last instruction it accepted. When a store-accumulator instruction wants to read the same accumulator that the instruction just before it wrote, the block holds it back for a fixed number of cycles and then lets it through.

A store that reads any other accumulator passes with no delay. A write followed by a non-accumulator instruction, or by a store, leaves nothing to wait for. The interlock only changes when an instruction is accepted. It never alters which instructions are accepted or the order in which they are accepted. The arithmetic, the accumulator storage and operand fetch are outside this block.

Top module: `mac_acc_interlock`

## Requirements
- R1: A store-accumulator (kind code 3) presented right after an accepted MAC (kind code 1) that named the same accumulator index sees `stall_o` high for exactly STALL_CYC (default 2) consecutive cycles. It is then accepted on the next cycle.
- R2: A load-accumulator (kind code 2) is a producer in the same way as a MAC. A same-index store right after it stalls exactly as in R1.
- R3: A store whose accumulator index differs from that of the immediately preceding producer is accepted on its first cycle, with no stall.
- R4: Only the immediately preceding accepted instruction is tracked. An accepted other instruction (kind code 0) or store clears the hazard, so a following store never stalls.
- R5: MAC, load-accumulator and other instructions never stall, whatever came before them.
- R6: After reset, `ready_o` is high, `stall_o` is low, and the first instruction presented is accepted without stalling.
- R7: `stall_o` is high only while `valid_i` is high, and `ready_o` is always its complement.
- R8: Cycles with `valid_i` low do not change the tracked producer. A same-index store presented after idle gaps still stalls the full STALL_CYC cycles, counted from its first presented cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction presented; held until accepted |
| op_i | input | 2 | Kind: 0 other, 1 MAC, 2 load-accumulator, 3 store-accumulator |
| acc_i | input | 2 | Accumulator index |
| ready_o | output | 1 | Instruction accepted this cycle when valid_i is high |
| stall_o | output | 1 | Issue held because of an accumulator hazard |

## Verification
The hardest case is a same-index store that reaches the interlock with idle cycles between it and its producer. A second hard case is a store held back by a stall, which must then itself clear the hazard for a store behind it. The bench reaches both from directed sequences. These insert bubbles of chosen length after a producer, and place two stores to the same accumulator back to back behind a MAC. A sweep over every producer/store index pair then follows, and finally a long pseudo-random stream with random gaps. The bench reference model counts how many cycles each instruction has been presented, not a countdown. This makes the two-cycle window an independent check.

// File: rtl/mac_ilk_pkg.sv
package mac_ilk_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_MAC   = 2'd1,
    OP_LDACC = 2'd2,
    OP_STACC = 2'd3
  } op_e;
endpackage

// File: rtl/mac_ilk_track.sv
module mac_ilk_track
  import mac_ilk_pkg::*;
#(
  parameter int ACC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fire_i,
  input  op_e              op_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             hazard_o
);
  logic             prod_vld_q;
  logic [ACC_W-1:0] prod_acc_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_vld_q <= 1'b0;
      prod_acc_q <= '0;
      seen_q     <= 1'b0;
    end else if (fire_i) begin
      prod_vld_q <= (op_i == OP_MAC) || (op_i == OP_LDACC);
      prod_acc_q <= acc_i;
      seen_q     <= 1'b1;
    end
  end

  assign hazard_o = valid_i && (op_i == OP_STACC) && prod_vld_q && (prod_acc_q == acc_i);

  p_first_no_hazard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !hazard_o);
  p_same_acc_hazard_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire_i) && ($past(op_i) == OP_MAC || $past(op_i) == OP_LDACC) &&
     valid_i && op_i == OP_STACC && acc_i == $past(acc_i)) |-> hazard_o);
  p_diff_acc_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire_i) && valid_i && op_i == OP_STACC && acc_i != $past(acc_i)) |-> !hazard_o);
  p_nonprod_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire_i) && ($past(op_i) == OP_OTHER || $past(op_i) == OP_STACC)) |-> !hazard_o);
endmodule

// File: rtl/mac_ilk_hold.sv
module mac_ilk_hold #(
  parameter int STALL_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hazard_i,
  output logic stall_o
);
  localparam int CW = (STALL_CYC < 2) ? 1 : $clog2(STALL_CYC + 1);

  logic          wait_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] run_q;

  assign stall_o = valid_i && (wait_q ? (cnt_q != '0) : hazard_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!wait_q) begin
      if (hazard_i) begin
        wait_q <= 1'b1;
        cnt_q  <= CW'(STALL_CYC - 1);
      end
    end else if (valid_i) begin
      if (cnt_q == '0) wait_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // length of the current run of stall cycles, checker only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (stall_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_stall_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (run_q < CW'(STALL_CYC)));
  p_stall_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stall_o) && valid_i) |-> (run_q == CW'(STALL_CYC)));
endmodule

// File: rtl/mac_acc_interlock.sv
module mac_acc_interlock
  import mac_ilk_pkg::*;
#(
  parameter int NUM_ACC   = 4,
  parameter int STALL_CYC = 2,
  localparam int ACC_W    = $clog2(NUM_ACC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             ready_o,
  output logic             stall_o
);
  logic hazard;
  logic fire;
  op_e  op;

  assign op      = op_e'(op_i);
  assign ready_o = !stall_o;
  assign fire    = valid_i && ready_o;

  mac_ilk_track #(.ACC_W(ACC_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .fire_i  (fire),
    .op_i    (op),
    .acc_i   (acc_i),
    .hazard_o(hazard)
  );

  mac_ilk_hold #(.STALL_CYC(STALL_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .hazard_i(hazard),
    .stall_o (stall_o)
  );

  p_stall_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> valid_i);
  p_producer_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op != OP_STACC) |-> !stall_o);
endmodule

// File: tb/sim_mac_acc_interlock.sv
module sim_mac_acc_interlock;
  localparam int OTH = 0, MAC = 1, LDA = 2, STA = 3;
  localparam int NSTALL = 2;

  logic clk = 0, rst_n = 0;
  logic valid = 0;
  logic [1:0] op = 0, acc = 0;
  logic ready, stall;
  int n_chk = 0, n_fail = 0;

  // reference state: last accepted instruction
  bit m_prod = 0;
  int m_acc  = 0;

  always #2 clk = ~clk;

  mac_acc_interlock u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .acc_i(acc),
    .ready_o(ready), .stall_o(stall)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic send(int o, int a, string req);
    bit haz;
    int pres;
    bit done;
    haz  = m_prod && (o == STA) && (a == m_acc);
    pres = 0;
    done = 0;
    valid = 1; op = 2'(o); acc = 2'(a);
    while (!done) begin
      #1;
      chk(req, stall, haz && pres < NSTALL);
      chk("R7", ready, !(haz && pres < NSTALL));
      @(posedge clk);
      if (haz && pres < NSTALL) pres++;
      else begin
        done   = 1;
        m_prod = (o == MAC) || (o == LDA);
        m_acc  = a;
      end
      @(negedge clk);
    end
    valid = 0;
  endtask

  task automatic idle(int n);
    valid = 0;
    for (int i = 0; i < n; i++) begin
      op = 2'(i); acc = 2'(i + 1);
      #1;
      chk("R7", stall, 1'b0);
      chk("R7", ready, 1'b1);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    #1;
    chk("R6", stall, 1'b0);
    chk("R6", ready, 1'b1);
    rst_n = 1;
    @(negedge clk);
    idle(2);
    send(STA, 0, "R6");
    send(MAC, 0, "R5");
    send(STA, 0, "R1");
    send(LDA, 2, "R5");
    send(STA, 2, "R2");
    send(MAC, 1, "R5");
    send(STA, 3, "R3");
    send(LDA, 1, "R5");
    send(STA, 0, "R3");
    send(MAC, 1, "R5");
    send(OTH, 1, "R5");
    send(STA, 1, "R4");
    send(MAC, 0, "R5");
    send(STA, 0, "R1");
    send(STA, 0, "R4");
    send(MAC, 3, "R5");
    send(MAC, 3, "R5");
    send(LDA, 3, "R5");
    send(OTH, 3, "R5");
    send(LDA, 3, "R5");
    send(STA, 3, "R2");
    send(MAC, 2, "R5");
    idle(3);
    send(STA, 2, "R8");
    send(LDA, 1, "R5");
    idle(1);
    send(STA, 1, "R8");
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        send((p % 2) ? LDA : MAC, p, "R5");
        send(STA, s, (p == s) ? "R1" : "R3");
      end
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[6:5] == 2'b00) idle(int'(lfsr[8:7]) + 1);
      send(int'(lfsr[1:0]), int'(lfsr[3:2]), (lfsr[1:0] == 2'd3) ? "R4" : "R5");
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule